// File: doc/BRIEF.md
# Two-Channel Four-Phase CDS Sequencer

This block drives the phase enables of one switched-capacitor pipeline stage. The stage has two capacitor channels that take turns on a single shared amplifier. Each channel runs a four-step cycle in a fixed order: sample, compare, preliminary amplify, main amplify. Channel 1 runs the same cycle as channel 0, delayed by two phases. As a result, exactly one channel holds the amplifier in every phase, and the comparator gets a whole phase to decide.

Each phase lasts one clock cycle. A two-bit phase counter advances on every enabled cycle, and registered decode logic turns it into one-hot enables for each channel. The same logic produces a comparator latch strobe and a residue-valid pulse, each tagged with the channel it belongs to. The sampling qualifier of each channel is its sample enable gated by one shared early reference level. Because both qualifiers fall on that one signal, their ending edges coincide.

Top module: `cds_phase_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every registered output is zero after that edge and the phase counter returns to phase 1. The first enabled cycle after reset therefore shows channel 0 in sample.
- R2: Channel 0 enables are one-hot or zero. The bit positions are: bit 0 sample, bit 1 compare, bit 2 preliminary amplify, bit 3 main amplify. Over consecutive enabled cycles channel 0 steps through bit 0, bit 1, bit 2, bit 3 and back to bit 0.
- R3: Channel 1 enables use the same bit positions and always equal channel 0 shifted by two phases. When channel 0 samples, channel 1 is in preliminary amplify. When channel 0 compares, channel 1 is in main amplify, and so on.
- R4: In every enabled cycle exactly one channel is in an amplify phase (bit 2 or bit 3). The two channels never claim the amplifier together.
- R5: `cmp_strobe` is high exactly in the cycles where one channel is in compare. `cmp_ch` then gives that channel: 0 in phase 2, 1 in phase 4.
- R6: `res_valid` is high exactly in the cycles where one channel is in main amplify. `res_ch` then gives that channel: 1 in phase 2, 0 in phase 4. This yields one result every two phases, alternating between the channels.
- R7: A clock edge with `en` low drives all enables, `cmp_strobe` and `res_valid` to zero and holds the phase counter. The next enabled cycle shows the phase that would have come next.
- R8: `samp_q[0]` equals channel 0 sample enable AND `edge_ref`, and `samp_q[1]` equals channel 1 sample enable AND `edge_ref`. This path is combinational from `edge_ref`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one phase per cycle |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the sequence this cycle |
| edge_ref | input | 1 | Shared early reference that ends both sampling qualifiers |
| ch0_ph | output | 4 | Channel 0 phase enables {main, pre, compare, sample} |
| ch1_ph | output | 4 | Channel 1 phase enables, same encoding |
| samp_q | output | 2 | Sampling qualifiers, bit i for channel i |
| cmp_strobe | output | 1 | Sub-ADC latch strobe |
| cmp_ch | output | 1 | Channel whose comparison is strobed |
| res_valid | output | 1 | Residue-valid pulse |
| res_ch | output | 1 | Channel whose residue is valid |

## Verification
A corrupted phase counter shows at the ports on the very next enabled cycle. Channel 0 then leaves its sample, compare, pre, main order, and the tagged strobe and residue flags point at the wrong channel. A wrong channel offset or a bad decode makes both channels claim the amplifier, or lets an enable go non-one-hot, in the same cycle it happens. A broken enable hold shows up on the first enabled cycle after an idle gap: the phase shown is not the one that was due next.

// File: rtl/cds_phase_seq.sv
module cds_phase_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       edge_ref,
  output logic [3:0] ch0_ph,
  output logic [3:0] ch1_ph,
  output logic [1:0] samp_q,
  output logic       cmp_strobe,
  output logic       cmp_ch,
  output logic       res_valid,
  output logic       res_ch
);

  logic [1:0] cnt;
  logic [1:0] cnt_far;

  assign cnt_far = cnt + 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= 2'd0;
      ch0_ph     <= 4'b0;
      ch1_ph     <= 4'b0;
      cmp_strobe <= 1'b0;
      cmp_ch     <= 1'b0;
      res_valid  <= 1'b0;
      res_ch     <= 1'b0;
    end else if (en) begin
      cnt        <= cnt + 2'd1;
      ch0_ph     <= 4'b0001 << cnt;
      ch1_ph     <= 4'b0001 << cnt_far;
      cmp_strobe <= cnt[0];
      cmp_ch     <= cnt[1];
      res_valid  <= cnt[0];
      res_ch     <= ~cnt[1];
    end else begin
      ch0_ph     <= 4'b0;
      ch1_ph     <= 4'b0;
      cmp_strobe <= 1'b0;
      res_valid  <= 1'b0;
    end
  end

  assign samp_q = {ch1_ph[0], ch0_ph[0]} & {2{edge_ref}};

endmodule

// File: rtl/cds_phase_seq_chk.sv
module cds_phase_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       edge_ref,
  input logic [3:0] ch0_ph,
  input logic [3:0] ch1_ph,
  input logic [1:0] samp_q,
  input logic       cmp_strobe,
  input logic       cmp_ch,
  input logic       res_valid,
  input logic       res_ch
);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (ch0_ph == 4'b0 && ch1_ph == 4'b0 && !cmp_strobe && !res_valid)); // R1
  AST_CH0_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ch0_ph)); // R2
  AST_CH0_STEP: assert property (@(posedge clk) disable iff (rst) (en && ch0_ph[0]) |=> ch0_ph[1]); // R2
  AST_CH1_OFFSET: assert property (@(posedge clk) disable iff (rst) ch1_ph == {ch0_ph[1:0], ch0_ph[3:2]}); // R3
  AST_AMP_EXCL: assert property (@(posedge clk) disable iff (rst) !((ch0_ph[2] | ch0_ph[3]) && (ch1_ph[2] | ch1_ph[3]))); // R4
  AST_STROBE_TAG: assert property (@(posedge clk) disable iff (rst) cmp_strobe |-> (cmp_ch ? ch1_ph[1] : ch0_ph[1])); // R5
  AST_RES_TAG: assert property (@(posedge clk) disable iff (rst) res_valid |-> (res_ch ? ch1_ph[3] : ch0_ph[3])); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !en |=> (ch0_ph == 4'b0 && !res_valid && !cmp_strobe)); // R7
  AST_QUAL_GATE: assert property (@(posedge clk) disable iff (rst) samp_q[0] |-> (ch0_ph[0] && edge_ref)); // R8

endmodule

bind cds_phase_seq cds_phase_seq_chk u_chk (.*);

// File: tb/test_cds_phase_seq.sv
module test_cds_phase_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       edge_ref = 1'b0;
  logic [3:0] ch0_ph, ch1_ph;
  logic [1:0] samp_q;
  logic       cmp_strobe, cmp_ch, res_valid, res_ch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] m_cnt;
  logic [3:0] e0, e1;
  logic       e_stb, e_cch, e_rv, e_rch;

  always #2 clk = ~clk;

  cds_phase_seq i_cds_phase_seq (
    .clk(clk), .rst(rst), .en(en), .edge_ref(edge_ref),
    .ch0_ph(ch0_ph), .ch1_ph(ch1_ph), .samp_q(samp_q),
    .cmp_strobe(cmp_strobe), .cmp_ch(cmp_ch),
    .res_valid(res_valid), .res_ch(res_ch)
  );

  function automatic logic [3:0] ph_of(input logic [1:0] step);
    case (step)
      2'd0: return 4'b0001;
      2'd1: return 4'b0010;
      2'd2: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic predict();
    if (rst) begin
      m_cnt = 2'd0; e0 = 4'b0; e1 = 4'b0; e_stb = 1'b0; e_cch = 1'b0; e_rv = 1'b0; e_rch = 1'b0;
    end else if (en) begin
      e0 = ph_of(m_cnt);
      e1 = ph_of(m_cnt + 2'd2);
      e_stb = (m_cnt == 2'd1) || (m_cnt == 2'd3);
      e_cch = (m_cnt == 2'd3);
      e_rv = e_stb;
      e_rch = (m_cnt == 2'd1);
      m_cnt = m_cnt + 2'd1;
    end else begin
      e0 = 4'b0; e1 = 4'b0; e_stb = 1'b0; e_rv = 1'b0;
    end
  endtask

  task automatic check_all();
    chk("R2", ch0_ph, e0);
    chk("R3", ch1_ph, e1);
    chk("R4", ((ch0_ph[2] | ch0_ph[3]) + (ch1_ph[2] | ch1_ph[3])), (e0 != 4'b0) ? 1 : 0);
    chk("R5", cmp_strobe, e_stb);
    if (e_stb) chk("R5", cmp_ch, e_cch);
    chk("R6", res_valid, e_rv);
    if (e_rv) chk("R6", res_ch, e_rch);
    chk("R8", samp_q, {e1[0], e0[0]} & {2{edge_ref}});
  endtask

  task automatic step(input logic r, input logic e, input logic q);
    rst = r; en = e; edge_ref = q;
    predict();
    @(negedge clk);
    check_all();
    edge_ref = ~q;
    #0.5;
    chk("R8", samp_q, {e1[0], e0[0]} & {2{edge_ref}});
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 2'd0;
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R1", {ch0_ph, ch1_ph, cmp_strobe, res_valid}, 10'b0);
    step(1'b0, 1'b1, 1'b1);
    chk("R1", ch0_ph, 4'b0001);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    chk("R7", {ch0_ph, ch1_ph, cmp_strobe, res_valid}, 10'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R1", ch0_ph, 4'b0);
    step(1'b0, 1'b1, 1'b1);
    chk("R1", ch0_ph, 4'b0001);
    for (int i = 0; i < 3000; i++) begin
      logic r, e, q;
      r = ($urandom % 100) < 2;
      e = ($urandom % 100) < 75;
      q = $urandom % 2;
      step(r, e, q);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule